// File: doc/BRIEF.md
# Synchronous Clock Fan-out Gating Controller

This block is the digital control path of a four-bank clock fan-out buffer. A reference clock level, sampled by the block clock, is steered to eight outputs, arranged as four banks of two. An edge-select input chooses whether the rising or the falling reference edge is the active edge. Every enable decision, divider step and idle transition happens only on that edge. A gate request input parks banks at a quiet idle level without cutting a pulse short. Bank C always keeps running, because it carries the feedback path.

Bank C can also divide the reference by two or by four. A bypass-level input selects an inversion mode for the undivided outputs. It also selects a per-bank mode in which each bank's own select code can switch that bank off. Each three-level control is carried as a 2-bit code. Each of banks A to C takes a 4-bit select word made of two such codes: bits [3:2] are the first select and bits [1:0] are the second. Bank D has no select word.

Top module: `clk_fanout_gate`

## Requirements
- R1: While reset is asserted, and after release until the first active reference edge, every output rests at the inverse of `edge_sel`.
- R2: An enabled, undivided, non-inverted output equals the reference level that the previous rising clock edge sampled.
- R3: A bank's enable state changes only on an active edge: the reference rising when `edge_sel`=1, falling when `edge_sel`=0. A disable request therefore never shortens a pulse that is in progress.
- R4: With `gate_off`=1 and a bypass code that is not mid, banks A, B and D go idle from the next active edge, while bank C keeps running.
- R5: The idle level of a disabled bank is the inverse of `edge_sel`, and it follows `edge_sel` at once.
- R6: With bypass code high (10) and `edge_sel`=0, undivided outputs are the inverse of the reference, so a 20% high input gives 80% high outputs. With `edge_sel`=1 they are not inverted.
- R7: A divide-by-two output toggles on every active edge and a divide-by-four output toggles on every second active edge. Both keep a 50% duty cycle and neither is ever inverted.
- R8: Bank C divides by four when its select word is 0000 (both low) and by two when it is 1010 (both high). Any other word passes the reference undivided. Banks A and B never divide.
- R9: With bypass code mid and `gate_off`=1, each of banks A, B and C is enabled unless both of its selects are low. Bank D is disabled.
- R10: Clearing `gate_off` re-enables a bank only on the next active edge, so the first output pulse is a whole one.
- R11: Three-level codes are 00 low, 01 mid and 10 high. The code 11 is treated as mid, both on the bypass input and on the selects.
- R12: The two outputs of a bank are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the reference |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_lvl | input | 1 | Reference clock level |
| edge_sel | input | 1 | 1: rising edge active, 0: falling edge active |
| gate_off | input | 1 | 1 requests gating of the banks |
| bypass_lvl | input | 2 | Three-level bypass code |
| cfg_a | input | 4 | Bank A select word |
| cfg_b | input | 4 | Bank B select word |
| cfg_c | input | 4 | Bank C select word (divide control) |
| q_a | output | PAIR_W | Bank A outputs |
| q_b | output | PAIR_W | Bank B outputs |
| q_c | output | PAIR_W | Bank C outputs (feedback bank) |
| q_d | output | PAIR_W | Bank D outputs |

## Verification
The checker watches four things on every cycle. Bank D must hold still while the reference does not move. A gate request at an active edge must leave bank D idle. The feedback bank must keep following the reference under a gate request. The bypass inversion must hold. The idle levels during reset are checked on every cycle as well. The bench's directed scenarios are needed for the divider duty and toggle counts, the 20%-to-80% duty inversion, the per-bank select decoding including code 11, and the whole-pulse behaviour when gating and re-enabling. A cycle-level expectation model, built from the requirements, compares all eight outputs on every sampled cycle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [1:0] {
    TL_LOW  = 2'b00,
    TL_MID  = 2'b01,
    TL_HIGH = 2'b10
  } tlvl_e;

  typedef enum logic [1:0] {
    SRC_PASS = 2'b00,
    SRC_DIV2 = 2'b01,
    SRC_DIV4 = 2'b10
  } src_e;

  localparam int SEL_W = 4;
  localparam int CNT_W = 2;

  // Unused code 11 folds onto the middle level.
  function automatic tlvl_e tl_decode(input logic [1:0] code);
    tlvl_e lvl;
    case (code)
      2'b00:   lvl = TL_LOW;
      2'b10:   lvl = TL_HIGH;
      default: lvl = TL_MID;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/cfg_edge_det.sv
module cfg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_lvl,
  input  logic edge_sel,
  output logic ref_q,
  output logic act
);
  logic ref_d;

  always_comb begin
    ref_d = ref_lvl;
    if (edge_sel) act = ref_lvl & ~ref_q;
    else          act = ~ref_lvl & ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end
endmodule

// File: rtl/cfg_div_cnt.sv
module cfg_div_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_bank_ctrl.sv
module cfg_bank_ctrl
  import cfg_pkg::*;
#(
  parameter int PAIR_W      = 2,
  parameter bit HAS_SEL     = 1'b1,
  parameter bit IS_FEEDBACK = 1'b0,
  parameter bit CAN_DIVIDE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              ref_q,
  input  logic              edge_sel,
  input  logic              gate_off,
  input  tlvl_e             byp,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CNT_W-1:0]  div_q,
  output logic [PAIR_W-1:0] q
);
  tlvl_e s_hi;
  tlvl_e s_lo;
  logic  both_low;
  logic  both_high;
  logic  req;
  logic  en_q;
  logic  en_d;
  logic  inv;
  logic  lvl;
  src_e  mode;

  always_comb begin
    s_hi      = tl_decode(sel[3:2]);
    s_lo      = tl_decode(sel[1:0]);
    both_low  = (s_hi == TL_LOW)  && (s_lo == TL_LOW);
    both_high = (s_hi == TL_HIGH) && (s_lo == TL_HIGH);
  end

  // Requested enable, taken only on an active edge.
  always_comb begin
    if (!gate_off)          req = 1'b1;
    else if (byp == TL_MID) req = HAS_SEL && !both_low;
    else                    req = IS_FEEDBACK;
  end

  always_comb begin
    en_d = en_q;
    if (act) en_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  always_comb begin
    mode = SRC_PASS;
    if (CAN_DIVIDE && both_low)       mode = SRC_DIV4;
    else if (CAN_DIVIDE && both_high) mode = SRC_DIV2;
  end

  always_comb begin
    inv = (byp == TL_HIGH) && !edge_sel;
    case (mode)
      SRC_DIV2: lvl = div_q[0];
      SRC_DIV4: lvl = div_q[1];
      default:  lvl = ref_q ^ inv;
    endcase
  end

  assign q = {PAIR_W{en_q ? lvl : ~edge_sel}};
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
  import cfg_pkg::*;
#(
  parameter int PAIR_W     = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_lvl,
  input  logic              edge_sel,
  input  logic              gate_off,
  input  logic [1:0]        bypass_lvl,
  input  logic [3:0]        cfg_a,
  input  logic [3:0]        cfg_b,
  input  logic [3:0]        cfg_c,
  output logic [PAIR_W-1:0] q_a,
  output logic [PAIR_W-1:0] q_b,
  output logic [PAIR_W-1:0] q_c,
  output logic [PAIR_W-1:0] q_d
);
  localparam int NUM_BANKS = 4;
  localparam int FB_BANK   = 2;
  localparam int SOLO_BANK = NUM_BANKS - 1;

  logic             rst_int;
  logic             ref_q;
  logic             act;
  logic [CNT_W-1:0] div_q;
  tlvl_e            byp;
  logic [SEL_W-1:0] sel_bus [NUM_BANKS];
  logic [PAIR_W-1:0] q_bus  [NUM_BANKS];

  assign byp        = tl_decode(bypass_lvl);
  assign sel_bus[0] = cfg_a;
  assign sel_bus[1] = cfg_b;
  assign sel_bus[2] = cfg_c;
  assign sel_bus[3] = {TL_MID, TL_MID};

  cfg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int)
  );

  cfg_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_int),
    .ref_lvl  (ref_lvl),
    .edge_sel (edge_sel),
    .ref_q    (ref_q),
    .act      (act)
  );

  cfg_div_cnt #(.W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_int),
    .step  (act),
    .cnt_q (div_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    cfg_bank_ctrl #(
      .PAIR_W      (PAIR_W),
      .HAS_SEL     (b != SOLO_BANK),
      .IS_FEEDBACK (b == FB_BANK),
      .CAN_DIVIDE  (b == FB_BANK)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_int),
      .act      (act),
      .ref_q    (ref_q),
      .edge_sel (edge_sel),
      .gate_off (gate_off),
      .byp      (byp),
      .sel      (sel_bus[b]),
      .div_q    (div_q),
      .q        (q_bus[b])
    );
  end

  assign q_a = q_bus[0];
  assign q_b = q_bus[1];
  assign q_c = q_bus[2];
  assign q_d = q_bus[3];
endmodule

// File: rtl/clk_fanout_gate_chk.sv
module clk_fanout_gate_chk #(
  parameter int PAIR_W = 2
) (
  input logic              clk,
  input logic              arst_n,
  input logic              srst_n,
  input logic              ref_lvl,
  input logic              edge_sel,
  input logic              gate_off,
  input logic [1:0]        bypass_lvl,
  input logic [3:0]        cfg_c,
  input logic [PAIR_W-1:0] q_a,
  input logic [PAIR_W-1:0] q_b,
  input logic [PAIR_W-1:0] q_c,
  input logic [PAIR_W-1:0] q_d
);
  logic ref_d;
  logic act;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ref_d <= 1'b0;
    else         ref_d <= ref_lvl;
  end

  assign act = edge_sel ? (ref_lvl && !ref_d) : (!ref_lvl && ref_d);

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !arst_n |-> (q_a == {PAIR_W{~edge_sel}}) && (q_b == {PAIR_W{~edge_sel}}) &&
                (q_c == {PAIR_W{~edge_sel}}) && (q_d == {PAIR_W{~edge_sel}})); // R1

  AST_QUIET_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(ref_lvl) == $past(ref_lvl, 2)) && (edge_sel == $past(edge_sel)) &&
    (bypass_lvl == $past(bypass_lvl)) |-> $stable(q_d)); // R3

  AST_GATED_BANK_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    act && gate_off |=> (q_d == {PAIR_W{~edge_sel}})); // R4

  AST_FEEDBACK_RUNS: assert property (@(posedge clk) disable iff (!srst_n)
    $past(act) && $past(gate_off) && ($past(bypass_lvl) == 2'b00) &&
    (bypass_lvl == 2'b00) && (cfg_c == 4'b0101)
    |-> (q_c == {PAIR_W{$past(ref_lvl)}})); // R4

  AST_BYPASS_INVERTS: assert property (@(posedge clk) disable iff (!srst_n)
    $past(act) && !$past(gate_off) && ($past(bypass_lvl) == 2'b10) &&
    (bypass_lvl == 2'b10) && !edge_sel && !$past(edge_sel)
    |-> (q_d == {PAIR_W{~$past(ref_lvl)}})); // R6
endmodule

bind clk_fanout_gate clk_fanout_gate_chk #(.PAIR_W(PAIR_W)) u_chk (
  .clk        (clk),
  .arst_n     (rst_n),
  .srst_n     (rst_int),
  .ref_lvl    (ref_lvl),
  .edge_sel   (edge_sel),
  .gate_off   (gate_off),
  .bypass_lvl (bypass_lvl),
  .cfg_c      (cfg_c),
  .q_a        (q_a),
  .q_b        (q_b),
  .q_c        (q_c),
  .q_d        (q_d)
);

// File: tb/sim_clk_fanout_gate.sv
module sim_clk_fanout_gate;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic       clk        = 1'b0;
  logic       rst_n      = 1'b1;
  logic       ref_lvl    = 1'b0;
  logic       edge_sel   = 1'b1;
  logic       gate_off   = 1'b0;
  logic [1:0] bypass_lvl = 2'b00;
  logic [3:0] cfg_a      = 4'b0101;
  logic [3:0] cfg_b      = 4'b0101;
  logic [3:0] cfg_c      = 4'b0101;
  logic [1:0] q_a, q_b, q_c, q_d;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  bit         m_on = 1'b0;
  logic [3:0] m_en;
  logic [1:0] m_cnt;
  logic       m_ref;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_fanout_gate u0 (
    .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl), .edge_sel(edge_sel),
    .gate_off(gate_off), .bypass_lvl(bypass_lvl), .cfg_a(cfg_a),
    .cfg_b(cfg_b), .cfg_c(cfg_c), .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_d(q_d)
  );

  function automatic logic [1:0] tl(input logic [1:0] c);
    return (c == 2'b11) ? 2'b01 : c;
  endfunction

  function automatic logic [3:0] sel_of(input int b);
    case (b)
      0:       return cfg_a;
      1:       return cfg_b;
      2:       return cfg_c;
      default: return 4'b0101;
    endcase
  endfunction

  function automatic logic req_of(input int b);
    logic [3:0] s;
    s = sel_of(b);
    if (!gate_off) return 1'b1;
    if (tl(bypass_lvl) == 2'b01) begin
      if (b == 3) return 1'b0;
      return !((tl(s[3:2]) == 2'b00) && (tl(s[1:0]) == 2'b00));
    end
    return (b == 2);
  endfunction

  function automatic logic exp_of(input int b);
    logic [3:0] s;
    logic       v;
    s = sel_of(b);
    v = m_ref ^ ((tl(bypass_lvl) == 2'b10) && !edge_sel);
    if (b == 2) begin
      if ((tl(s[3:2]) == 2'b00) && (tl(s[1:0]) == 2'b00))      v = m_cnt[1];
      else if ((tl(s[3:2]) == 2'b10) && (tl(s[1:0]) == 2'b10)) v = m_cnt[0];
    end
    return m_en[b] ? v : ~edge_sel;
  endfunction

  function automatic logic [1:0] q_of(input int b);
    case (b)
      0:       return q_a;
      1:       return q_b;
      2:       return q_c;
      default: return q_d;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input logic [1:0] got,
                       input logic [1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got=%b expected=%b at %0t", what, got, exp, $time);
    end
  endtask

  // Expectation model: state advances on the sampling edge.
  always @(posedge clk) begin
    logic act;
    if (!m_on) begin
      m_en  = 4'b0000;
      m_cnt = 2'b00;
      m_ref = 1'b0;
    end else begin
      act = edge_sel ? (ref_lvl && !m_ref) : (!ref_lvl && m_ref);
      if (act) begin
        for (int b = 0; b < 4; b++) m_en[b] = req_of(b);
        m_cnt = m_cnt + 2'b01;
      end
      m_ref = ref_lvl;
    end
  end

  always @(negedge clk) begin
    if (m_on) begin
      for (int b = 0; b < 4; b++)
        check(q_of(b) == {2{exp_of(b)}},
              $sformatf("%s model bank %0d", cur_req, b), q_of(b), {2{exp_of(b)}});
    end
  end

  task automatic drive_ref(input logic v);
    @(negedge clk);
    #1 ref_lvl = v;
  endtask

  task automatic run_ref(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < hi; k++) drive_ref(1'b1);
      for (int k = 0; k < lo; k++) drive_ref(1'b0);
    end
  endtask

  task automatic count_highs(input int bank, input int hi, input int lo,
                             input int n, output int highs);
    logic [1:0] v;
    highs = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < hi + lo; k++) begin
        @(negedge clk);
        v = q_of(bank);
        highs += v[0];
        #1 ref_lvl = (k < hi);
      end
    end
  endtask

  task automatic t_reset;
    cur_req = "R1";
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(q_a == 2'b00 && q_b == 2'b00 && q_c == 2'b00 && q_d == 2'b00,
          "R1 idle low in reset", q_d, 2'b00);
    #1 edge_sel = 1'b0;
    @(negedge clk);
    check(q_a == 2'b11 && q_c == 2'b11 && q_d == 2'b11,
          "R1 R5 idle high in reset", q_a, 2'b11);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(q_b == 2'b11 && q_d == 2'b11, "R1 idle after release", q_b, 2'b11);
    end
    #1 edge_sel = 1'b1;
    m_on = 1'b1;
  endtask

  task automatic t_normal;
    cur_req = "R2";
    run_ref(4, 4, 3);
    drive_ref(1'b1);
    @(negedge clk);
    check(q_a == 2'b11, "R2 follows high level", q_a, 2'b11);
    drive_ref(1'b0);
    @(negedge clk);
    check(q_b == 2'b00, "R2 follows low level", q_b, 2'b00);
    cur_req = "R12";
    #1 edge_sel = 1'b0;
    run_ref(3, 5, 3);
    check(q_c[0] == q_c[1], "R12 pair equal", q_c, {2{q_c[0]}});
  endtask

  task automatic t_edge_gate;
    cur_req = "R3";
    edge_sel = 1'b1;
    run_ref(4, 4, 2);
    drive_ref(1'b1);
    drive_ref(1'b1);
    gate_off = 1'b1;
    drive_ref(1'b1);
    @(negedge clk);
    check(q_d == 2'b11, "R3 pulse not cut", q_d, 2'b11);
    for (int k = 0; k < 4; k++) drive_ref(1'b0);
    drive_ref(1'b1);
    @(negedge clk);
    check(q_d == 2'b00, "R3 R4 gated at rising edge", q_d, 2'b00);
    check(q_c == 2'b11, "R4 feedback bank runs", q_c, 2'b11);
    cur_req = "R10";
    drive_ref(1'b1);
    gate_off = 1'b0;
    drive_ref(1'b1);
    @(negedge clk);
    check(q_d == 2'b00, "R10 no partial pulse on enable", q_d, 2'b00);
    for (int k = 0; k < 4; k++) drive_ref(1'b0);
    drive_ref(1'b1);
    @(negedge clk);
    check(q_d == 2'b11, "R10 whole pulse after edge", q_d, 2'b11);
    for (int k = 0; k < 3; k++) drive_ref(1'b0);
    cur_req = "R3";
    edge_sel = 1'b0;
    run_ref(4, 4, 2);
    drive_ref(1'b1);
    gate_off = 1'b1;
    drive_ref(1'b0);
    @(negedge clk);
    check(q_a == 2'b11, "R3 falling edge gates high", q_a, 2'b11);
    run_ref(4, 4, 2);
  endtask

  task automatic t_feedback;
    cur_req = "R4";
    gate_off = 1'b1;
    edge_sel = 1'b1;
    run_ref(4, 4, 3);
    drive_ref(1'b1);
    @(negedge clk);
    check(q_c == 2'b11 && q_b == 2'b00, "R4 only feedback runs", q_c, 2'b11);
    cur_req = "R5";
    drive_ref(1'b0);
    edge_sel = 1'b0;
    @(negedge clk);
    check(q_d == 2'b11, "R5 idle follows edge select", q_d, 2'b11);
    run_ref(4, 4, 2);
    gate_off = 1'b0;
    run_ref(4, 4, 2);
  endtask

  task automatic t_bypass;
    int highs;
    cur_req = "R6";
    bypass_lvl = 2'b10;
    edge_sel = 1'b0;
    run_ref(2, 8, 2);
    count_highs(3, 2, 8, 4, highs);
    check(highs == 32, "R6 inverted duty 80pct", highs[1:0], 2'b00);
    edge_sel = 1'b1;
    run_ref(2, 8, 2);
    count_highs(0, 2, 8, 4, highs);
    check(highs == 8, "R6 plain duty 20pct", highs[1:0], 2'b00);
    bypass_lvl = 2'b00;
    run_ref(4, 4, 1);
  endtask

  task automatic t_divide;
    int highs;
    cur_req = "R7";
    cfg_c = 4'b1010;
    cfg_a = 4'b0000;
    edge_sel = 1'b1;
    run_ref(4, 4, 2);
    count_highs(2, 4, 4, 4, highs);
    check(highs == 16, "R7 div2 half duty", highs[1:0], 2'b00);
    cur_req = "R8";
    drive_ref(1'b1);
    @(negedge clk);
    check(q_a == 2'b11, "R8 bank A never divides", q_a, 2'b11);
    for (int k = 0; k < 3; k++) drive_ref(1'b1);
    for (int k = 0; k < 4; k++) drive_ref(1'b0);
    cfg_c = 4'b0000;
    run_ref(4, 4, 4);
    count_highs(2, 4, 4, 8, highs);
    check(highs == 32, "R8 R7 div4 half duty", highs[1:0], 2'b00);
    cur_req = "R7";
    bypass_lvl = 2'b10;
    edge_sel = 1'b0;
    cfg_c = 4'b1010;
    run_ref(4, 4, 4);
    count_highs(2, 4, 4, 4, highs);
    check(highs == 16, "R7 divided not inverted", highs[1:0], 2'b00);
    bypass_lvl = 2'b00;
    cfg_a = 4'b0101;
    cfg_c = 4'b0101;
    edge_sel = 1'b1;
    run_ref(4, 4, 2);
  endtask

  task automatic t_per_bank;
    cur_req = "R9";
    gate_off = 1'b1;
    bypass_lvl = 2'b01;
    cfg_a = 4'b0000;
    cfg_b = 4'b0110;
    cfg_c = 4'b1010;
    run_ref(4, 4, 3);
    drive_ref(1'b1);
    @(negedge clk);
    check(q_a == 2'b00, "R9 bank A off by select", q_a, 2'b00);
    check(q_b == 2'b11, "R9 bank B on", q_b, 2'b11);
    check(q_d == 2'b00, "R9 bank D off", q_d, 2'b00);
    for (int k = 0; k < 3; k++) drive_ref(1'b1);
    for (int k = 0; k < 4; k++) drive_ref(1'b0);
    cur_req = "R11";
    bypass_lvl = 2'b11;
    cfg_a = 4'b1111;
    cfg_c = 4'b1111;
    run_ref(4, 4, 3);
    drive_ref(1'b1);
    @(negedge clk);
    check(q_a == 2'b11, "R11 code 11 is mid on select", q_a, 2'b11);
    check(q_c == 2'b11, "R11 code 11 not divide", q_c, 2'b11);
    check(q_d == 2'b00, "R11 code 11 is mid on bypass", q_d, 2'b00);
    drive_ref(1'b0);
    @(negedge clk);
    check(q_c == 2'b00, "R11 bank C passes low", q_c, 2'b00);
    run_ref(4, 4, 2);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got=timeout expected=finish");
    report();
  end

  initial begin
    t_reset();
    t_normal();
    t_edge_gate();
    t_feedback();
    t_bypass();
    t_divide();
    t_per_bank();
    report();
  end
endmodule